// File: doc/BRIEF.md
# Modulo Alarm Timer

This block is a register-mapped alarm counter. A 16-bit counter advances on a selectable source, either every system clock cycle or a slow fixed-frequency tick that arrives as a one-cycle enable. The source passes through a power-of-two prescaler. The counter climbs from a programmable start value up to a programmable terminal value. On the next count it returns to the start value and raises a wrap flag. If the interrupt enable is set, the wrap flag drives the interrupt line.

Software programs the block through a simple synchronous register bus. Every request is accepted in the cycle it is presented, so the bus has no back-pressure and no ready signal. Read data appears on the cycle after the request. A one-shot alarm of K counts uses a start value of 0 and a terminal value of K-1.

The wrap flag is cleared by writing 0 to its bit. If that write lands in the same cycle as a wrap, the flag stays set and software must clear it again.

Top module: `mod_alarm_timer`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0, the counter (0x04) reads 0, the terminal value (0x08) reads 0xFFFF, the start value (0x4C) reads 0, and irq is low. Read data is valid one cycle after the read request.
- R2: Control bits 4:3 choose the count source. Code 0 and code 3 stop the counter. Code 1 advances it on every system clock cycle. Code 2 advances it on each cycle where tick_en is high.
- R3: Control bits 2:0 hold N. The counter advances once per 2^N source pulses. The prescaler is cleared while the source code is 0, so after enabling, the first count comes on the 2^N-th source pulse.
- R4: On each count, the counter increments by one unless it equals the terminal value. In that case it loads the start value instead.
- R5: Bit 7 of the control word is the wrap flag. Only a count that loads the start value from the terminal value sets it. Writing 1 to bit 7 leaves it unchanged.
- R6: A write of any data to offset 0x04 loads the start value into the counter, and the written data is ignored. In that cycle the reload takes priority over any count.
- R7: A control write with bit 7 at 0 clears the wrap flag. If a wrap happens in the same cycle, the flag stays set.
- R8: irq is high exactly when the wrap flag and the interrupt enable (control bit 6) are both 1.
- R9: The counter, terminal value and start value keep only bits 15:0 of a write and read 0 in bits 31:16. An offset not listed in R1 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Fixed-frequency tick, one cycle wide |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | Alarm interrupt |

## Verification
Vectors in a table run the counter for a set number of clock cycles. Each vector varies the source code, the prescaler exponent, the start value and the terminal value. A bench model predicts the final count and the wrap flag for each vector.

The vectors are chosen to separate specific faults:
- Free counts against a terminal value of 0 separate increment from reload.
- Alternating ticks separate the tick source from the system clock source.
- Exponents 1, 2 and 7 reveal a prescaler that is off by one or not cleared.
- A stopped source reveals a counter that keeps moving.

Directed sequences place a flag clear exactly on a wrap cycle, and then one cycle away from it. They also place a counter write on a live count edge, which tells reload priority apart from increment.

// File: rtl/alarm_pkg.sv
`timescale 1ns/1ps
package alarm_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 7'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 7'h04;
  localparam logic [ADDR_W-1:0] OFF_TOP  = 7'h08;
  localparam logic [ADDR_W-1:0] OFF_INIT = 7'h4C;

  localparam int unsigned BIT_FLAG = 7;
  localparam int unsigned BIT_IEN  = 6;
  localparam int unsigned SRC_LO   = 3;
  localparam int unsigned PS_LO    = 0;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_TICK = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;
endpackage

// File: rtl/alarm_prescaler.sv
`timescale 1ns/1ps
module alarm_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  alarm_pkg::src_e     src,
  input  logic                tick_en,
  input  logic [PS_W-1:0]     ps,
  output logic                count_pulse
);
  import alarm_pkg::*;

  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             src_pulse;

  // Mask of the low divider bits that must all be set before a count.
  for (genvar gi = 0; gi < DIV_W; gi++) begin : g_mask
    assign mask[gi] = (ps > PS_W'(gi));
  end

  assign src_pulse   = (src == SRC_SYS) || ((src == SRC_TICK) && tick_en);
  assign count_pulse = src_pulse && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (src == SRC_OFF) begin
      div_q <= '0;
    end else if (src_pulse) begin
      div_q <= div_q + 1'b1;
    end
  end

  AST_STOP_CLEARS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_OFF) |=> (div_q == '0)); // R3
  AST_RSVD_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_RSVD) |-> !count_pulse); // R2
endmodule

// File: rtl/alarm_counter.sv
`timescale 1ns/1ps
module alarm_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          reload,
  input  logic [CW-1:0] init_val,
  input  logic [CW-1:0] top_val,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  assign wrap = step && !reload && (cnt == top_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (reload || wrap) begin
      cnt <= init_val;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_STEP_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload && (cnt != top_val)) |=> (cnt == CW'($past(cnt) + 1'b1))); // R4
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == $past(init_val))); // R4
  AST_WRITE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(init_val))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !reload) |=> $stable(cnt)); // R2
endmodule

// File: rtl/alarm_regs.sv
`timescale 1ns/1ps
module alarm_regs #(
  parameter int unsigned CW     = 16,
  parameter int unsigned PS_W   = 3,
  parameter int unsigned ADDR_W = alarm_pkg::ADDR_W,
  parameter int unsigned DATA_W = alarm_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CW-1:0]     cnt,
  input  logic              wrap,
  output alarm_pkg::src_e   src,
  output logic [PS_W-1:0]   ps,
  output logic [CW-1:0]     init_val,
  output logic [CW-1:0]     top_val,
  output logic              cnt_reload,
  output logic              irq
);
  import alarm_pkg::*;

  logic flag_q;
  logic ien_q;
  logic wr_ctrl, wr_top, wr_init, rd_req;
  logic [DATA_W-1:0] ctrl_word;

  assign rd_req     = bus_en && !bus_we;
  assign wr_ctrl    = bus_en && bus_we && (bus_addr == OFF_CTRL);
  assign wr_top     = bus_en && bus_we && (bus_addr == OFF_TOP);
  assign wr_init    = bus_en && bus_we && (bus_addr == OFF_INIT);
  assign cnt_reload = bus_en && bus_we && (bus_addr == OFF_CNT);
  assign irq        = flag_q && ien_q;

  always_comb begin
    ctrl_word                    = '0;
    ctrl_word[BIT_FLAG]          = flag_q;
    ctrl_word[BIT_IEN]           = ien_q;
    ctrl_word[SRC_LO +: 2]       = src;
    ctrl_word[PS_LO +: PS_W]     = ps;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q    <= 1'b0;
      src      <= SRC_OFF;
      ps       <= '0;
      top_val  <= '1;
      init_val <= '0;
    end else begin
      if (wr_ctrl) begin
        ien_q <= bus_wdata[BIT_IEN];
        src   <= src_e'(bus_wdata[SRC_LO +: 2]);
        ps    <= bus_wdata[PS_LO +: PS_W];
      end
      if (wr_top)  top_val  <= bus_wdata[CW-1:0];
      if (wr_init) init_val <= bus_wdata[CW-1:0];
    end
  end

  // Hardware set wins over a software clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (wrap) begin
      flag_q <= 1'b1;
    end else if (wr_ctrl && !bus_wdata[BIT_FLAG]) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_req) begin
      case (bus_addr)
        OFF_CTRL: bus_rdata <= ctrl_word;
        OFF_CNT:  bus_rdata <= DATA_W'(cnt);
        OFF_TOP:  bus_rdata <= DATA_W'(top_val);
        OFF_INIT: bus_rdata <= DATA_W'(init_val);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  AST_FLAG_ONLY_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wrap)); // R5
  AST_COLLIDE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && wr_ctrl && !bus_wdata[BIT_FLAG]) |=> flag_q); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[BIT_FLAG] && !wrap) |=> !flag_q); // R7
  AST_WRITE_ONE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[BIT_FLAG] && !wrap && !flag_q) |=> !flag_q); // R5
endmodule

// File: rtl/mod_alarm_timer.sv
`timescale 1ns/1ps
module mod_alarm_timer #(
  parameter int unsigned CW     = 16,
  parameter int unsigned PS_W   = 3,
  parameter int unsigned ADDR_W = alarm_pkg::ADDR_W,
  parameter int unsigned DATA_W = alarm_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import alarm_pkg::*;

  src_e            src;
  logic [PS_W-1:0] ps;
  logic [CW-1:0]   init_val, top_val, cnt;
  logic            cnt_reload, step, wrap;

  alarm_regs #(.CW(CW), .PS_W(PS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .wrap(wrap),
    .src(src), .ps(ps), .init_val(init_val), .top_val(top_val),
    .cnt_reload(cnt_reload), .irq(irq)
  );

  alarm_prescaler #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .src(src), .tick_en(tick_en),
    .ps(ps), .count_pulse(step)
  );

  alarm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .reload(cnt_reload),
    .init_val(init_val), .top_val(top_val), .cnt(cnt), .wrap(wrap)
  );

  AST_IRQ_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wrap) || $past(bus_en && bus_we && (bus_addr == OFF_CTRL)))); // R8
endmodule

// File: tb/test_mod_alarm_timer.sv
`timescale 1ns/1ps
module test_mod_alarm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mod_alarm_timer i_mod_alarm_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [6:0] A_CTRL = 7'h00, A_CNT = 7'h04, A_TOP = 7'h08, A_INIT = 7'h4C;

  typedef struct packed {
    logic [1:0]  src;
    logic [2:0]  ps;
    logic [15:0] init;
    logic [15:0] top;
    logic [7:0]  p;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 3'd0, 16'h0000, 16'hFFFF, 8'd10},
    '{2'd1, 3'd0, 16'h0000, 16'h0004, 8'd12},
    '{2'd1, 3'd2, 16'h0000, 16'hFFFF, 8'd13},
    '{2'd1, 3'd1, 16'h0010, 16'h0012, 8'd9},
    '{2'd2, 3'd0, 16'h0000, 16'hFFFF, 8'd9},
    '{2'd3, 3'd0, 16'h0005, 16'hFFFF, 8'd6},
    '{2'd1, 3'd0, 16'h0000, 16'h0000, 8'd5},
    '{2'd1, 3'd7, 16'h0000, 16'hFFFF, 8'd130}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; write takes effect at the next posedge.
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  // Reference from the requirements: final {flag, count} after p cycles.
  function automatic logic [16:0] model(input vec_t v);
    logic [6:0]  d = '0;
    logic [15:0] c = v.init;
    logic        t = 1'b0;
    logic [6:0]  m = 7'((1 << v.ps) - 1);
    for (int i = 1; i <= int'(v.p); i++) begin
      bit sp = (v.src == 2'd1) || ((v.src == 2'd2) && (i % 2 == 1));
      if (sp) begin
        if ((d & m) == m) begin
          if (c == v.top) begin c = v.init; t = 1'b1; end
          else c = c + 16'd1;
        end
        d = d + 7'd1;
      end
    end
    return {t, c};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [16:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, r); chk("R1 ctrl", r, 32'h0);
    rd(A_CNT, r);  chk("R1 cnt", r, 32'h0);
    rd(A_TOP, r);  chk("R1 top", r, 32'h0000FFFF);
    rd(A_INIT, r); chk("R1 init", r, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // Table walk: R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      wr(A_CTRL, 32'h0);
      wr(A_INIT, {16'h0, v.init});
      wr(A_TOP, {16'h0, v.top});
      wr(A_CNT, 32'h0);
      wr(A_CTRL, {24'h0, 3'b000, v.src, v.ps});
      tick_en = 1'b1;
      for (int i = 2; i <= int'(v.p); i++) begin
        @(negedge clk);
        tick_en = (i % 2 == 1);
      end
      wr(A_CTRL, 32'h80); // stop; writing 1 to the flag must not change it
      tick_en = 1'b0;
      e = model(v);
      rd(A_CNT, r);  chk("R4/R2/R3 count", r, {16'h0, e[15:0]});
      rd(A_CTRL, r); chk("R5 flag", r, {24'h0, e[16], 7'h0});
    end

    // R9 width and unmapped offsets
    wr(A_CTRL, 32'h0);
    wr(A_TOP, 32'hABCD1234);
    rd(A_TOP, r); chk("R9 top upper zero", r, 32'h00001234);
    wr(A_INIT, 32'h00000050);
    wr(7'h0C, 32'hFFFFFFFF);
    rd(7'h0C, r); chk("R9 unmapped read", r, 32'h0);
    rd(A_INIT, r); chk("R9 unmapped write inert", r, 32'h00000050);

    // R6 counter write loads start value, data ignored
    wr(A_CNT, 32'h0000FFFF);
    rd(A_CNT, r); chk("R6 reload ignores data", r, 32'h00000050);
    wr(A_CTRL, 32'h08);
    wr(A_CNT, 32'h00001111);   // on a live count edge: reload wins
    wr(A_CTRL, 32'h80);        // one more count, then stop
    rd(A_CNT, r); chk("R6 reload priority", r, 32'h00000051);

    // R5 writing 1 to flag with flag clear
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h80);
    rd(A_CTRL, r); chk("R5 write one inert", r, 32'h0);

    // R7 / R8 clear colliding with a wrap
    wr(A_INIT, 32'h0);
    wr(A_TOP, 32'h3);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h48);        // edge E0; wraps at E4 and E8
    repeat (7) @(negedge clk);
    wr(A_CTRL, 32'h48);        // clear at E8, same cycle as wrap
    rd(A_CTRL, r); chk("R7 collision keeps flag", r, 32'h000000C8);
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h48);        // clear at E10, no wrap
    rd(A_CTRL, r); chk("R7 clear works", r, 32'h00000048);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule